// File: doc/BRIEF.md
# MDIO Management Bus Master

This block lets a host reach PHY management registers over the two-wire management bus. The host sees two 32-bit registers. One register is the command word: a single write to it, with the start bit set, sends one complete management frame. The other register holds the bus timing settings, an idle flag and the last value read back. The block derives the management clock from the system clock and drives the data line through a separate output enable. During the turnaround and data bits of a read frame it releases the line and shifts in the PHY's reply.

Clause 22 frames are single operations. Clause 45 traffic takes two commands from software. The first is an address frame that loads the target register number. The second is a write, a read or a post-read-increment read. Software waits for the start bit to clear before it issues the next command.

The frame engine is a state machine with five named states: `ST_IDLE`, `ST_PRE` (32 preamble ones), `ST_HDR` (start, opcode and both addresses), `ST_TURN` (two turnaround bits) and `ST_DATA` (16 data bits). The transitions are:
- IDLE→PRE on an accepted start.
- PRE→HDR, HDR→TURN and TURN→DATA on the clock fall that ends bit 31, bit 45 and bit 47.
- DATA→IDLE on the fall that ends bit 63.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset the status register (offset 4) shows idle (bit 16 = 1) and read data zero (bits 15:0). The command register (offset 0) bit 31 reads 0. The management clock is low and the data output enable is low.
- R2: A write to offset 0 with bit 31 = 1 while idle starts a frame. A read of offset 0 on the next cycle returns bit 31 = 1, and status bit 16 reads 0.
- R3: The frame lasts exactly 64 management-clock periods, 128·(T+1) system clocks, where T is status bits 31:24. After that, command bit 31 returns to 0 and status bit 16 to 1.
- R4: On successive management-clock rising edges the data line carries, MSB first, the following fields:
  - 32 ones;
  - the start code: 01 when command bit 28 = 1 (clause 22), 00 when it is 0 (clause 45);
  - the opcode, command bits 27:26;
  - the port address, bits 25:21;
  - the register/device address, bits 20:16;
  - the turnaround, driven as 10 on non-read frames;
  - 16 data bits, taken from bits 15:0.
- R5: Read frames are clause 22 with opcode 10, or clause 45 with opcode 10 or 11. On these the output enable is low for the last 18 bits. On every other frame it is high for all 64 bits.
- R6: At the end of a read frame, status bits 15:0 hold the 16 sampled bits, first sampled in the MSB.
- R7: The management clock stays high for T+1 system clocks per pulse, and low for T+1. It stays low while idle.
- R8: Status bit 23 = 0 samples D+1 system clocks after the rising edge inside each data bit. Bit 23 = 1 samples D+1 clocks after the falling edge that opens the bit. D is status bits 22:20, and D ≤ T is required.
- R9: A command write with bit 31 = 0 is ignored, and so is any command write made while a frame is in progress. Neither starts a frame nor alters the frame or the stored command fields.
- R10: Non-read frames leave status bits 15:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset (0 command, 4 status) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Data line input from the pad |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
If the bit counter or the state register goes wrong, the failure shows within one management-clock period. A field lands on the wrong rising edge, or the output enable drops on the wrong bit. The busy time also stops matching 128·(T+1) clocks exactly. A bad sampling point or shift gives a wrong read value, but that only shows at the status register once the frame ends. If the command gate is wrong, the next-cycle readback of bit 31 is wrong at once, or a second write during a frame alters the bits that follow on the wire.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_HDR, ST_TURN, ST_DATA} fstate_t;

    localparam int DATA_W   = 16;
    localparam int PADDR_W  = 5;
    localparam int THR_W    = 8;
    localparam int DLY_W    = 3;
    localparam int PRE_BITS = 32;

    // command register fields
    localparam int FIRE_BIT = 31;
    localparam int TYPE_BIT = 28;
    localparam int OP_LO    = 26;
    localparam int PHY_LO   = 21;
    localparam int REG_LO   = 16;

    // status register fields
    localparam int THR_LO   = 24;
    localparam int EDGE_BIT = 23;
    localparam int DLY_LO   = 20;
    localparam int IDLE_BIT = 16;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [THR_W-1:0] thr,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [THR_W-1:0] cnt;
    logic             tick;

    assign tick = run && (cnt >= thr);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: clock parked low whenever no frame runs
    p_mdc_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
    import mgmt_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = PADDR_W,
    parameter int TW    = THR_W,
    parameter int LW    = DLY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          is_c22,
    input  logic [1:0]    op,
    input  logic [AW-1:0] phy,
    input  logic [AW-1:0] rga,
    input  logic [DW-1:0] wdat,
    input  logic [TW-1:0] thr,
    input  logic          edge_fall,
    input  logic [LW-1:0] lat_dly,
    input  logic          mdio_i,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    output logic          busy,
    output logic [DW-1:0] rd_value
);
    localparam int FRAME_BITS = PRE_BITS + 4 + 2*AW + 2 + DW;
    localparam int BW         = $clog2(FRAME_BITS);
    localparam int HDR_AT     = PRE_BITS;
    localparam int TURN_AT    = PRE_BITS + 4 + 2*AW;
    localparam int DATA_AT    = TURN_AT + 2;
    localparam int LAST       = FRAME_BITS - 1;

    fstate_t                 state;
    logic [BW-1:0]           bitn;
    logic [FRAME_BITS-1:0]   frm;
    logic                    rd_q;
    logic                    rise, fall, done, go_rd;
    logic [BW-1:0]           pidx;
    logic                    arm, take, pend;
    logic [LW-1:0]           scnt;
    logic [DW-1:0]           sh, sh_next;

    mgmt_mdc_gen #(.THR_W(TW)) u_mdc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .thr  (thr),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    assign busy  = (state != ST_IDLE);
    assign go_rd = is_c22 ? (op == 2'b10) : op[1];
    assign done  = (state == ST_DATA) && fall && (bitn == BW'(LAST));
    assign pidx  = BW'(LAST) - bitn;

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            bitn  <= '0;
            frm   <= '0;
            rd_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    state <= ST_PRE;
                    bitn  <= '0;
                    rd_q  <= go_rd;
                    frm   <= {{PRE_BITS{1'b1}}, (is_c22 ? 2'b01 : 2'b00), op, phy, rga,
                              2'b10, (go_rd ? {DW{1'b0}} : wdat)};
                end
                ST_PRE:  if (fall && bitn == BW'(HDR_AT - 1))  state <= ST_HDR;
                ST_HDR:  if (fall && bitn == BW'(TURN_AT - 1)) state <= ST_TURN;
                ST_TURN: if (fall && bitn == BW'(DATA_AT - 1)) state <= ST_DATA;
                ST_DATA: if (done) state <= ST_IDLE;
            endcase
            if (busy && fall) bitn <= done ? '0 : bitn + 1'b1;
        end
    end

    // line outputs
    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        if (busy) begin
            mdio_o  = frm[pidx];
            mdio_oe = !(rd_q && (state == ST_TURN || state == ST_DATA));
        end
    end

    // read sampler
    assign arm = rd_q && (edge_fall
                 ? (fall && bitn >= BW'(DATA_AT - 1) && bitn < BW'(LAST))
                 : (rise && state == ST_DATA));
    assign take    = pend && (scnt == '0);
    assign sh_next = take ? {sh[DW-2:0], mdio_i} : sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            scnt     <= '0;
            sh       <= '0;
            rd_value <= '0;
        end else begin
            if (arm) begin
                pend <= 1'b1;
                scnt <= lat_dly;
            end else if (take) begin
                pend <= 1'b0;
            end else if (pend) begin
                scnt <= scnt - 1'b1;
            end
            sh <= sh_next;
            if (done && rd_q) rd_value <= sh_next;
        end
    end

    // R3: busy holds until the final clock fall of bit 63
    p_busy_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);
    // R5: line released throughout read data bits
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q && state == ST_DATA |-> !mdio_oe);
    // R10: read value only moves at the end of a read frame
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && rd_q) |=> $stable(rd_value));
endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
    import mgmt_pkg::*;
#(
    parameter int          ADDR_W  = 3,
    parameter int          CTRL_OFS = 0,
    parameter int          STAT_OFS = 4,
    parameter logic [7:0]  RST_THR = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe
);
    logic [30:0]       ctrl_q;
    logic [THR_W-1:0]  thr_q;
    logic              edge_q;
    logic [DLY_W-1:0]  dly_q;
    logic              wr_ctrl, wr_stat, go, busy;
    logic [DATA_W-1:0] rd_value;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(STAT_OFS));
    assign go      = wr_ctrl && bus_wdata[FIRE_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            thr_q  <= RST_THR;
            edge_q <= 1'b0;
            dly_q  <= '0;
        end else begin
            if (go) ctrl_q <= bus_wdata[30:0];
            if (wr_stat) begin
                thr_q  <= bus_wdata[THR_LO +: THR_W];
                edge_q <= bus_wdata[EDGE_BIT];
                dly_q  <= bus_wdata[DLY_LO +: DLY_W];
            end
        end
    end

    mgmt_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .is_c22   (bus_wdata[TYPE_BIT]),
        .op       (bus_wdata[OP_LO +: 2]),
        .phy      (bus_wdata[PHY_LO +: PADDR_W]),
        .rga      (bus_wdata[REG_LO +: PADDR_W]),
        .wdat     (bus_wdata[DATA_W-1:0]),
        .thr      (thr_q),
        .edge_fall(edge_q),
        .lat_dly  (dly_q),
        .mdio_i   (mdio_in),
        .mdc      (mdc),
        .mdio_o   (mdio_out),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .rd_value (rd_value)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS))
            bus_rdata = {busy, ctrl_q};
        else if (bus_addr == ADDR_W'(STAT_OFS))
            bus_rdata = {thr_q, edge_q, dly_q, 3'b000, !busy, rd_value};
    end

    // R2: an accepted start shows as busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    // R9: command writes while busy leave stored fields alone
    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && busy |=> $stable(ctrl_q));
    // R9: start bit clear never launches a frame from idle
    p_nofire_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !bus_wdata[FIRE_BIT] && !busy |=> !busy);
endmodule

// File: tb/mgmt_mdio_master_test.sv
module mgmt_mdio_master_test;
    typedef struct packed {
        logic        c22;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic [15:0] resp;
        logic        edgef;
        logic [2:0]  dly;
        logic [7:0]  thr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b01, 5'h03, 5'h04, 16'hA5C3, 16'h0000, 1'b0, 3'd0, 8'd1},
        '{1'b1, 2'b10, 5'h1F, 5'h02, 16'h0000, 16'h1234, 1'b0, 3'd0, 8'd2},
        '{1'b0, 2'b00, 5'h05, 5'h1E, 16'hBEEF, 16'h0000, 1'b0, 3'd0, 8'd0},
        '{1'b0, 2'b01, 5'h05, 5'h1E, 16'h0F0F, 16'h0000, 1'b0, 3'd0, 8'd3},
        '{1'b0, 2'b11, 5'h11, 5'h07, 16'h0000, 16'h8001, 1'b1, 3'd3, 8'd3},
        '{1'b0, 2'b10, 5'h0A, 5'h15, 16'h0000, 16'hC3A5, 1'b0, 3'd2, 8'd2},
        '{1'b1, 2'b10, 5'h00, 5'h00, 16'h0000, 16'h7FFE, 1'b1, 3'd0, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_in, mdio_out, mdio_oe;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] cap, cap_oe;
    int          nrise, bitc, hcnt, first_high;
    logic        prev_mdc = 1'b0;
    logic [15:0] resp_cur = '0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    mgmt_mdio_master uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .mdc      (mdc),
        .mdio_in  (mdio_in),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    // PHY responder: drives data bits of the frame once the opening fall is seen
    assign mdio_in = (bitc >= 48 && bitc <= 63) ? resp_cur[63 - bitc] : 1'b1;

    always @(negedge clk) begin
        if (mdc && !prev_mdc) begin
            cap    <= {cap[62:0], mdio_out};
            cap_oe <= {cap_oe[62:0], mdio_oe};
            nrise  <= nrise + 1;
            hcnt   <= 1;
        end else if (mdc) begin
            hcnt <= hcnt + 1;
        end
        if (!mdc && prev_mdc) begin
            bitc <= bitc + 1;
            if (first_high < 0) first_high <= hcnt;
        end
        prev_mdc <= mdc;
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic mon_clear();
        cap = '0; cap_oe = '0; nrise = 0; bitc = 0; hcnt = 0; first_high = -1;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] s;
        cyc = 0;
        rd(3'd4, s);
        while (!s[16] && cyc < 100000) begin
            cyc++;
            @(negedge clk);
            rd(3'd4, s);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input vec_t v);
        return {1'b1, 2'b00, v.c22, v.op, v.phy, v.rg, v.wd};
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] r;
        logic [63:0] exp_bits, exp_oe;
        logic        is_rd;
        int          cyc;
        is_rd    = v.c22 ? (v.op == 2'b10) : v.op[1];
        exp_bits = {32'hFFFF_FFFF, (v.c22 ? 2'b01 : 2'b00), v.op, v.phy, v.rg, 2'b10, v.wd};
        exp_oe   = is_rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        resp_cur = v.resp;
        wr(3'd4, {v.thr, v.edgef, v.dly, 20'h0});
        mon_clear();
        wr(3'd0, ctrl_word(v));
        rd(3'd0, r);
        chk(r[31] == 1'b1, $sformatf("R2 vec%0d busy readback", idx), 64'(r[31]), 64'd1);
        rd(3'd4, r);
        chk(r[16] == 1'b0, $sformatf("R2 vec%0d idle low", idx), 64'(r[16]), 64'd0);
        wait_idle(cyc);
        chk(cyc == 128 * (int'(v.thr) + 1), $sformatf("R3 vec%0d busy length", idx),
            64'(cyc), 64'(128 * (int'(v.thr) + 1)));
        rd(3'd0, r);
        chk(r[31] == 1'b0, $sformatf("R3 vec%0d start bit cleared", idx), 64'(r[31]), 64'd0);
        chk(nrise == 64, $sformatf("R3 vec%0d clock count", idx), 64'(nrise), 64'd64);
        chk(((cap ^ exp_bits) & exp_oe) == '0, $sformatf("R4 vec%0d frame bits", idx), cap, exp_bits);
        chk(cap_oe == exp_oe, $sformatf("R5 vec%0d output enable", idx), cap_oe, exp_oe);
        chk(first_high == int'(v.thr) + 1, $sformatf("R7 vec%0d high time", idx),
            64'(first_high), 64'(int'(v.thr) + 1));
        if (is_rd) last_rd = v.resp;
        rd(3'd4, r);
        chk(r[15:0] == last_rd, $sformatf("%s vec%0d read data (R8 edge=%0d dly=%0d)",
            is_rd ? "R6" : "R10", idx, v.edgef, v.dly), 64'(r[15:0]), 64'(last_rd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] exp_a;
        int          cyc;
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd4, r);
        chk(r[16] == 1'b1, "R1 idle after reset", 64'(r[16]), 64'd1);
        chk(r[15:0] == 16'h0, "R1 read data zero", 64'(r[15:0]), 64'd0);
        rd(3'd0, r);
        chk(r[31] == 1'b0, "R1 start bit clear", 64'(r[31]), 64'd0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 clock and enable low",
            64'({mdc, mdio_oe}), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R9: start bit clear does nothing
        mon_clear();
        wr(3'd0, 32'h1000_1234);
        repeat (20) @(negedge clk);
        rd(3'd4, r);
        chk(r[16] == 1'b1, "R9 no start without bit 31", 64'(r[16]), 64'd1);
        chk(nrise == 0 && mdc == 1'b0, "R9 clock idle without start", 64'(nrise), 64'd0);

        // R9: command write during a frame is ignored
        wr(3'd4, 32'h0000_0000);
        mon_clear();
        wr(3'd0, {1'b1, 2'b00, 1'b1, 2'b01, 5'h0C, 5'h09, 16'h3C96});
        repeat (40) @(negedge clk);
        wr(3'd0, {1'b1, 2'b00, 1'b1, 2'b01, 5'h13, 5'h16, 16'hC369});
        rd(3'd0, r);
        chk(r[25:21] == 5'h0C, "R9 stored port field kept", 64'(r[25:21]), 64'h0C);
        wait_idle(cyc);
        exp_a = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h09, 2'b10, 16'h3C96};
        chk(cap == exp_a, "R9 frame unchanged by busy write", cap, exp_a);
        rd(3'd4, r);
        chk(r[16] == 1'b1 && nrise == 64, "R9 single frame only", 64'(nrise), 64'd64);
        chk(r[15:0] == last_rd, "R10 write keeps read data", 64'(r[15:0]), 64'(last_rd));

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule